// File: doc/BRIEF.md
# Cascadable Dual Byte Compare Timer

This block holds two byte-wide up-counters, lane A and lane B, each paired with its own byte-wide compare register. On every cycle in which the count-enable input is high, the counters advance. When a counter reaches its compare value, the block raises a one-cycle interrupt pulse for that lane. In independent mode, the counter then restarts from zero on the following enabled cycle. The result is a periodic pulse every (compare + 1) enabled cycles.

Setting the cascade input joins the two lanes into one 16-bit timer. Lane A is the low byte and lane B is the high byte. Lane B advances only when lane A rolls over from 0xFF. The lane B interrupt then marks a full 16-bit match, and the lane A interrupt stays silent. A separate pulse-width-mode input mutes the lane A interrupt while leaving both counters and the lane B interrupt running. Software loads the compare registers one byte at a time through a small write port and can read both counters directly.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, both counters read 0x00, both interrupt outputs are low, and both compare registers hold 0x00.
- R2: When `cascade_i` is low, each counter increments by one on every cycle in which `tick_i` is high. No counter changes when `tick_i` is low.
- R3: When `cascade_i` is low and `tick_i` is high, a counter that currently equals its compare value loads 0x00 instead of incrementing.
- R4: When `cascade_i` is low, an interrupt output pulses high for exactly the cycle in which its counter has just been advanced to a value equal to its compare register. An interrupt output is never high unless `tick_i` was high on the previous cycle.
- R5: When `cascade_i` is high, lane A increments on every enabled cycle. Lane B increments only on an enabled cycle in which lane A rolls over from 0xFF to 0x00.
- R6: When `cascade_i` is high, `irq_b_o` pulses only when lane A equals its compare register and lane B equals its compare register after the same advance. `irq_a_o` stays low.
- R7: When `cascade_i` is high, an enabled cycle that starts with both lanes equal to their compare values loads 0x00 into both counters.
- R8: When `pwm_mode_i` is high, `irq_a_o` stays low. Counting and `irq_b_o` are unaffected.
- R9: A cycle with `wr_en_i` high loads `wr_data_i` into compare register A when `wr_addr_i` is 0, and into compare register B when `wr_addr_i` is 1. A write by itself does not change either counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable, one advance per high cycle |
| cascade_i | input | 1 | 1 joins the two lanes into a 16-bit counter |
| pwm_mode_i | input | 1 | 1 mutes the lane A interrupt |
| wr_en_i | input | 1 | Compare register write strobe |
| wr_addr_i | input | 1 | 0 selects compare A, 1 selects compare B |
| wr_data_i | input | 8 | Compare value to write |
| cnt_a_o | output | 8 | Lane A count (low byte in cascade) |
| cnt_b_o | output | 8 | Lane B count (high byte in cascade) |
| irq_a_o | output | 1 | Lane A match pulse |
| irq_b_o | output | 1 | Lane B match pulse, 16-bit match in cascade |

## Verification
The bench first confirms that the compare registers come out of reset at zero. With a zero compare, one enabled cycle must leave lane A at 0x00 and still fire its interrupt; a design that left the compare undefined or counted past it would show 0x01. In cascade mode, the bench passes the point where the low byte alone matches and the point where the high byte alone matches. A design that ORed or ignored one half of the 16-bit compare would fire early at one of these points. It then checks the rollover that feeds lane B and the joint clear. The bench also confirms that swapping the compare register addresses, or letting pulse-width mode stop the counters, shows up as a missing or misplaced pulse.

// File: rtl/dct_pkg.sv
package dct_pkg;
    localparam int NUM_LANES = 2;
    localparam int LANE_A    = 0;
    localparam int LANE_B    = 1;

    typedef enum logic {
        SEL_CMP_A = 1'b0,
        SEL_CMP_B = 1'b1
    } cmp_sel_e;

    typedef struct packed {
        logic irq_a;
        logic irq_b;
    } irq_pair_t;
endpackage

// File: rtl/dct_cmp_regs.sv
module dct_cmp_regs #(
    parameter int W = 8,
    parameter int N = 2,
    localparam int SELW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [SELW-1:0]     wr_sel_i,
    input  logic [W-1:0]        wr_data_i,
    output logic [N-1:0][W-1:0] cmp_o
);
    logic [N-1:0][W-1:0] cmp_d, cmp_q;

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_comb begin
            cmp_d[i] = cmp_q[i];
            if (wr_en_i && (wr_sel_i == SELW'(i))) begin
                cmp_d[i] = wr_data_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cmp_q[i] <= '0;
            else        cmp_q[i] <= cmp_d[i];
        end

        // R9: an addressed write lands, an unaddressed register holds
        p_cmp_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && (wr_sel_i == SELW'(i))) |=> (cmp_q[i] == $past(wr_data_i)));
        p_cmp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en_i && (wr_sel_i == SELW'(i))) |=> $stable(cmp_q[i]));
    end

    assign cmp_o = cmp_q;
endmodule

// File: rtl/dct_lane.sv
module dct_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv_i,
    input  logic         clr_i,
    input  logic [W-1:0] cmp_i,
    output logic [W-1:0] cnt_o,
    output logic         match_o,
    output logic         hit_next_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (adv_i) begin
            cnt_d = clr_i ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o      = cnt_q;
    assign match_o    = (cnt_q == cmp_i);
    assign hit_next_o = (cnt_d == cmp_i);

    // R2: a lane never moves without its advance strobe
    p_lane_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(cnt_q));
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         cascade_i,
    input  logic         pwm_mode_i,
    input  logic         wr_en_i,
    input  logic         wr_addr_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] cnt_a_o,
    output logic [W-1:0] cnt_b_o,
    output logic         irq_a_o,
    output logic         irq_b_o
);
    import dct_pkg::*;

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic [NUM_LANES-1:0][W-1:0] cmp;
    logic [NUM_LANES-1:0][W-1:0] cnt;
    logic [NUM_LANES-1:0]        adv, clr, match, hit_next;
    logic                        full_match, wrap_a;
    irq_pair_t                   irq_d, irq_q;

    dct_cmp_regs #(.W(W), .N(NUM_LANES)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_addr_i),
        .wr_data_i (wr_data_i),
        .cmp_o     (cmp)
    );

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        dct_lane #(.W(W)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .adv_i      (adv[l]),
            .clr_i      (clr[l]),
            .cmp_i      (cmp[l]),
            .cnt_o      (cnt[l]),
            .match_o    (match[l]),
            .hit_next_o (hit_next[l])
        );
    end

    always_comb begin
        full_match  = match[LANE_A] & match[LANE_B];
        wrap_a      = (cnt[LANE_A] == ALL_ONES);
        adv[LANE_A] = tick_i;
        clr[LANE_A] = cascade_i ? full_match : match[LANE_A];
        adv[LANE_B] = cascade_i ? (tick_i & (full_match | wrap_a)) : tick_i;
        clr[LANE_B] = cascade_i ? full_match : match[LANE_B];

        irq_d.irq_a = tick_i & ~cascade_i & ~pwm_mode_i & hit_next[LANE_A];
        irq_d.irq_b = tick_i & hit_next[LANE_B] & (~cascade_i | hit_next[LANE_A]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign cnt_a_o = cnt[LANE_A];
    assign cnt_b_o = cnt[LANE_B];
    assign irq_a_o = irq_q.irq_a;
    assign irq_b_o = irq_q.irq_b;

    // R4: a pulse always follows an enabled cycle
    p_irq_a_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_a_o |-> $past(tick_i));
    p_irq_b_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_b_o |-> $past(tick_i));
    // R3: independent lane A restarts after reaching its compare value
    p_indep_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cascade_i && tick_i && cnt_a_o == cmp[LANE_A]) |=> (cnt_a_o == '0));
    // R5: high byte steps on low-byte rollover only
    p_casc_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade_i && tick_i && cnt_a_o == ALL_ONES &&
         !(cnt_a_o == cmp[LANE_A] && cnt_b_o == cmp[LANE_B]))
        |=> (cnt_b_o == W'($past(cnt_b_o) + 1'b1)));
    p_casc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade_i && cnt_a_o != ALL_ONES &&
         !(cnt_a_o == cmp[LANE_A] && cnt_b_o == cmp[LANE_B]))
        |=> $stable(cnt_b_o));
    // R6: low-byte interrupt silent in cascade
    p_casc_quiet_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_i |=> !irq_a_o);
    // R7: joint clear after a 16-bit match
    p_casc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade_i && tick_i && cnt_a_o == cmp[LANE_A] && cnt_b_o == cmp[LANE_B])
        |=> (cnt_a_o == '0 && cnt_b_o == '0));
    // R8: pulse-width mode mutes lane A
    p_pwm_mute_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_mode_i |=> !irq_a_o);
endmodule

// File: tb/dual_cmp_timer_bench.sv
module dual_cmp_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       cascade_i = 1'b0;
    logic       pwm_mode_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       wr_addr_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] cnt_a_o, cnt_b_o;
    logic       irq_a_o, irq_b_o;

    int n_tests = 0;
    int n_fail  = 0;
    int irq_a_cnt = 0;
    int irq_b_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_cmp_timer u_dual_cmp_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cascade_i(cascade_i),
        .pwm_mode_i(pwm_mode_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .cnt_a_o(cnt_a_o), .cnt_b_o(cnt_b_o),
        .irq_a_o(irq_a_o), .irq_b_o(irq_b_o)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // one cycle; inputs change 2 ns after the edge, results read there too
    task automatic step(input logic t);
        tick_i = t;
        @(posedge clk);
        #2;
        tick_i = 1'b0;
        if (irq_a_o) irq_a_cnt++;
        if (irq_b_o) irq_b_cnt++;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick_i = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        rst_n = 1'b1;
        irq_a_cnt = 0;
        irq_b_cnt = 0;
    endtask

    task automatic write_cmp(input logic sel, input logic [7:0] val);
        wr_en_i = 1'b1;
        wr_addr_i = sel;
        wr_data_i = val;
        @(posedge clk);
        #2;
        wr_en_i = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "cnt_a after reset", 16'(cnt_a_o), 16'h00);
        check("R1", "cnt_b after reset", 16'(cnt_b_o), 16'h00);
        check("R1", "irqs after reset", 16'({irq_a_o, irq_b_o}), 16'h0);
        step(1'b1);
        check("R1", "cnt_a with zero compare", 16'(cnt_a_o), 16'h00);
        check("R1", "irq_a with zero compare", 16'(irq_a_o), 16'h1);
    endtask

    task automatic t_independent();
        do_reset();
        write_cmp(1'b0, 8'd5);
        write_cmp(1'b1, 8'd9);
        check("R9", "counters untouched by write", {cnt_b_o, cnt_a_o}, 16'h0000);
        repeat (3) step(1'b1);
        check("R2", "counters after 3 ticks", {cnt_b_o, cnt_a_o}, 16'h0303);
        repeat (4) step(1'b0);
        check("R2", "counters hold when idle", {cnt_b_o, cnt_a_o}, 16'h0303);
        repeat (2) step(1'b1);
        check("R4", "cnt_a at compare", 16'(cnt_a_o), 16'h05);
        check("R4", "irq_a on reaching compare", 16'(irq_a_o), 16'h1);
        check("R9", "irq_b quiet at 5", 16'(irq_b_o), 16'h0);
        step(1'b0);
        check("R4", "irq_a single cycle", 16'(irq_a_o), 16'h0);
        step(1'b1);
        check("R3", "cnt_a cleared after match", 16'(cnt_a_o), 16'h00);
        check("R2", "cnt_b keeps counting", 16'(cnt_b_o), 16'h06);
        repeat (3) step(1'b1);
        check("R9", "irq_b at compare B", 16'(irq_b_o), 16'h1);
        step(1'b1);
        check("R3", "cnt_b cleared after match", 16'(cnt_b_o), 16'h00);
        check("R4", "pulse totals", 16'({irq_a_cnt[7:0], irq_b_cnt[7:0]}), 16'h0101);
    endtask

    task automatic t_pwm();
        do_reset();
        write_cmp(1'b0, 8'd2);
        write_cmp(1'b1, 8'd2);
        pwm_mode_i = 1'b1;
        repeat (2) step(1'b1);
        check("R8", "irq_a muted", 16'(irq_a_o), 16'h0);
        check("R8", "irq_b still fires", 16'(irq_b_o), 16'h1);
        step(1'b1);
        check("R8", "lane A still clears", 16'(cnt_a_o), 16'h00);
        pwm_mode_i = 1'b0;
    endtask

    task automatic t_cascade();
        do_reset();
        cascade_i = 1'b1;
        write_cmp(1'b0, 8'h03);
        write_cmp(1'b1, 8'h01);
        repeat (3) step(1'b1);
        check("R6", "low byte alone matching", 16'({irq_a_o, irq_b_o}), 16'h0);
        check("R5", "value at 3", {cnt_b_o, cnt_a_o}, 16'h0003);
        repeat (252) step(1'b1);
        check("R5", "value before rollover", {cnt_b_o, cnt_a_o}, 16'h00ff);
        step(1'b1);
        check("R5", "carry into high byte", {cnt_b_o, cnt_a_o}, 16'h0100);
        check("R6", "high byte alone matching", 16'(irq_b_o), 16'h0);
        repeat (3) step(1'b1);
        check("R6", "16-bit match pulse", 16'(irq_b_o), 16'h1);
        step(1'b1);
        check("R7", "joint clear", {cnt_b_o, cnt_a_o}, 16'h0000);
        check("R6", "no low-byte pulses", 16'(irq_a_cnt), 16'h0);
        check("R6", "one 16-bit pulse", 16'(irq_b_cnt), 16'h1);
        cascade_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_independent();
        t_pwm();
        t_cascade();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule